// File: doc/BRIEF.md
# Vector Register File Access Unit

This unit owns a 128-entry register file of 32-bit words arranged as eight 4x4 matrices. It carries out one short-vector read or write per request. A vector holds 1 to 4 elements and is picked by a 7-bit register specifier plus a 2-bit size code. The unit works out the physical index of each element from the specifier. Depending on a transpose flag, the elements run down a column or along a row, and they wrap around within the matrix.

Writes can leave individual elements untouched through a 4-bit suppression mask. Reads return the selected elements packed into a 128-bit result. Lanes beyond the vector length read as zero.

By default the unit handles one element per clock. With the `PARALLEL` parameter set, it handles every element of a request in a single clock. A request is taken only while `ready` is high. Completion is signalled by a single-cycle `done` pulse.

Top module: `vreg_access_unit`

## Requirements
- R1: Specifier bits [4:2] give the matrix m and bits [1:0] the column c. Without transpose, element i lives at index m*4 + c + ((r+i) mod 4)*32, where r is the starting row.
- R2: For sizes other than single, specifier bit 5 selects transpose. Element i then lives at index m*4 + ((r+i) mod 4) + c*32. For a single element, bit 5 has no transposing effect.
- R3: The starting row r depends on the size:
  - single: r is specifier bits [6:5];
  - pair and quad: r is 2 when bit 6 is set, else 0;
  - triple: r is bit 6 (0 or 1).
- R4: Size codes 0, 1, 2 and 3 give lengths 1, 2, 3 and 4. The code's upper bit comes from instruction bit 15 and its lower bit from instruction bit 7. Row positions wrap modulo 4.
- R5: On a write, element i is left unchanged when mask bit i is 1. A mask of 0 writes every element.
- R6: On a read, element i appears on `rd_data[32*i +: 32]`. Lanes at or beyond the length read as 0.
- R7: `done` is high for exactly one cycle per accepted request. In serial mode it rises len+1 cycles after the accepting edge, and `ready` returns in the following cycle.
- R8: A request presented while `ready` is low is ignored and has no effect on the register file.
- R9: After reset, every entry is 0, `ready` is 1, `done` is 0 and `rd_data` is 0.
- R10: With `PARALLEL` = 1, all elements are handled in one cycle, and `done` rises 2 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_spec | input | 7 | Register specifier |
| req_size | input | 2 | Size code (length minus one) |
| req_wdata | input | 128 | Write elements, lane i at bits 32*i+31:32*i |
| req_mask | input | 4 | Per-element write suppression |
| ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 128 | Read result, unused lanes zero |

## Verification
The two functions that can share a cycle are the completion of one request and the arrival of the next one. A second write is held on `req_valid` from the cycle after the first is taken, right through the `done` cycle. It is then judged by reading back its target locations and confirming they kept their earlier contents. A serial instance and a parallel instance are swept over every specifier at every size. Each read is compared against an arithmetic model of index placement and masking.

// File: rtl/vra_pkg.sv
// Shared geometry and state types for the vector register access unit.
// Assumes a fixed 4x4 matrix shape; matrix count sets the file depth.
package vra_pkg;
    localparam int MAT_DIM  = 4;
    localparam int MAT_CNT  = 8;
    localparam int LANES    = MAT_DIM;
    localparam int RF_DEPTH = MAT_CNT * MAT_DIM * MAT_DIM;
    localparam int IDX_W    = $clog2(RF_DEPTH);
    localparam int DIM_W    = $clog2(MAT_DIM);
    localparam int MAT_W    = $clog2(MAT_CNT);
    localparam int LEN_W    = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/vra_addr_gen.sv
// Element index generator: turns a specifier and size code into one physical
// register index per lane plus the vector length. Purely combinational.
// Assumes index layout {row, matrix, column} so row steps 32 entries apart.
module vra_addr_gen
    import vra_pkg::*;
(
    input  logic [IDX_W-1:0]            spec,
    input  logic [1:0]                  size,
    output logic [LANES-1:0][IDX_W-1:0] idx,
    output logic [LEN_W-1:0]            len
);
    logic [MAT_W-1:0] mat;
    logic [DIM_W-1:0] col;
    logic [DIM_W-1:0] row0;
    logic             trn;

    // Field split and size-dependent start row / orientation.
    always_comb begin
        mat = spec[DIM_W +: MAT_W];
        col = spec[DIM_W-1:0];
        trn = spec[DIM_W+MAT_W];
        len = LEN_W'(size) + LEN_W'(1);
        unique case (size)
            2'd0: begin
                row0 = spec[IDX_W-1 -: 2];
                trn  = 1'b0;
            end
            2'd2:    row0 = {1'b0, spec[IDX_W-1]};
            default: row0 = {spec[IDX_W-1], 1'b0};
        endcase
    end

    // One index per lane, row wraps modulo the matrix dimension.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DIM_W-1:0] r;
        always_comb begin
            r      = row0 + DIM_W'(g);
            idx[g] = trn ? {col, mat, r} : {r, mat, col};
        end
    end

    // R4 wrap keeps neighbouring lanes on distinct entries
    always_comb begin
        lane_distinct_chk: assert (idx[0] != idx[1]);
    end
endmodule

// File: rtl/vra_regfile.sv
// Register storage with PORTS independent write and read ports.
// Reads are combinational; writes land at the clock edge. Assumes callers
// never write one entry from two ports in the same cycle.
module vra_regfile
    import vra_pkg::*;
#(
    parameter int ELEM_W = 32,
    parameter int PORTS  = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [PORTS-1:0]                 we,
    input  logic [PORTS-1:0][IDX_W-1:0]      addr,
    input  logic [PORTS-1:0][ELEM_W-1:0]     wdata,
    output logic [PORTS-1:0][ELEM_W-1:0]     rdata
);
    logic [ELEM_W-1:0] mem [RF_DEPTH];

    // Clear on reset, otherwise apply each enabled write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < RF_DEPTH; e++) mem[e] <= '0;
        end else begin
            for (int p = 0; p < PORTS; p++)
                if (we[p]) mem[addr[p]] <= wdata[p];
        end
    end

    // Asynchronous read of each port's entry.
    always_comb begin
        for (int p = 0; p < PORTS; p++) rdata[p] = mem[addr[p]];
    end
endmodule

// File: rtl/vra_seq.sv
// Request sequencer: idle -> run for n_steps cycles -> one done cycle.
// Assumes n_steps is between 1 and LANES and stable while running.
module vra_seq
    import vra_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] n_steps,
    output logic             ready,
    output logic             accept,
    output logic             run,
    output logic [DIM_W-1:0] step,
    output logic             done
);
    seq_state_t       st;
    logic [DIM_W-1:0] cnt;

    // Decode state into handshake and phase flags.
    always_comb begin
        ready  = (st == ST_IDLE);
        accept = ready & req_valid;
        run    = (st == ST_RUN);
        done   = (st == ST_DONE);
        step   = cnt;
    end

    // State and element counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (accept) begin
                    st  <= ST_RUN;
                    cnt <= '0;
                end
                ST_RUN: begin
                    if (LEN_W'(cnt) == n_steps - LEN_W'(1)) st <= ST_DONE;
                    else cnt <= cnt + DIM_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7
    // done_single_chk
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    // accept_leaves_idle_chk
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);
    // R4
    // step_bound_chk
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (LEN_W'(step) < n_steps));
endmodule

// File: rtl/vreg_access_unit.sv
// Vector register file access unit: latches a request, derives per-element
// indices, and reads or masked-writes 1..4 elements either one per cycle
// (PARALLEL=0) or all in one cycle (PARALLEL=1). Requests taken only when idle.
module vreg_access_unit
    import vra_pkg::*;
#(
    parameter int ELEM_W   = 32,
    parameter int PARALLEL = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [IDX_W-1:0]        req_spec,
    input  logic [1:0]              req_size,
    input  logic [LANES*ELEM_W-1:0] req_wdata,
    input  logic [LANES-1:0]        req_mask,
    output logic                    ready,
    output logic                    done,
    output logic [LANES*ELEM_W-1:0] rd_data
);
    localparam int PORTS = (PARALLEL != 0) ? LANES : 1;

    logic                            accept, run;
    logic [DIM_W-1:0]                step;
    logic [IDX_W-1:0]                spec_q;
    logic [1:0]                      size_q;
    logic                            wr_q;
    logic [LANES-1:0][ELEM_W-1:0]    wdata_q;
    logic [LANES-1:0]                mask_q;
    logic [LANES-1:0][ELEM_W-1:0]    rd_q;
    logic [LANES-1:0][IDX_W-1:0]     idx;
    logic [LEN_W-1:0]                len;
    logic [LEN_W-1:0]                n_steps;
    logic [PORTS-1:0]                rf_we;
    logic [PORTS-1:0][IDX_W-1:0]     rf_addr;
    logic [PORTS-1:0][ELEM_W-1:0]    rf_wdata, rf_rdata;
    logic [LANES-1:0]                cap;
    logic [LANES-1:0][ELEM_W-1:0]    cap_val;

    vra_addr_gen u_addr (
        .spec (spec_q),
        .size (size_q),
        .idx  (idx),
        .len  (len)
    );

    vra_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .n_steps   (n_steps),
        .ready     (ready),
        .accept    (accept),
        .run       (run),
        .step      (step),
        .done      (done)
    );

    vra_regfile #(.ELEM_W(ELEM_W), .PORTS(PORTS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .addr  (rf_addr),
        .wdata (rf_wdata),
        .rdata (rf_rdata)
    );

    // Latch the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q  <= '0;
            size_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            spec_q  <= req_spec;
            size_q  <= req_size;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    if (PARALLEL != 0) begin : g_par
        // Every lane drives its own port in the single run cycle.
        always_comb begin
            n_steps = LEN_W'(1);
            for (int l = 0; l < LANES; l++) begin
                rf_addr[l]  = idx[l];
                rf_wdata[l] = wdata_q[l];
                rf_we[l]    = run && wr_q && (LEN_W'(l) < len) && !mask_q[l];
                cap[l]      = run && !wr_q && (LEN_W'(l) < len);
                cap_val[l]  = rf_rdata[l];
            end
        end
    end else begin : g_ser
        // One lane per cycle through a single port, selected by step.
        always_comb begin
            n_steps     = len;
            rf_addr[0]  = idx[step];
            rf_wdata[0] = wdata_q[step];
            rf_we[0]    = run && wr_q && !mask_q[step];
            for (int l = 0; l < LANES; l++) begin
                cap[l]     = run && !wr_q && (step == DIM_W'(l));
                cap_val[l] = rf_rdata[0];
            end
        end
    end

    // Clear the result on acceptance and capture each read lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (accept) begin
            rd_q <= '0;
        end else begin
            for (int l = 0; l < LANES; l++)
                if (cap[l]) rd_q[l] <= cap_val[l];
        end
    end

    assign rd_data = rd_q;

    // R6
    // unused_lane_zero_chk
    unused_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_q && (len != LEN_W'(LANES))) |-> (rd_q[LANES-1] == '0));
    // R8
    // spec_held_chk
    spec_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(spec_q));
endmodule

// File: tb/sim_vreg_access_unit.sv
`timescale 1ns/1ps
module sim_vreg_access_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_valid1 = 1'b0;
    logic         req_write = 1'b0;
    logic [6:0]   req_spec = '0;
    logic [1:0]   req_size = '0;
    logic [127:0] req_wdata = '0;
    logic [3:0]   req_mask = '0;
    logic         ready, done, ready1, done1;
    logic [127:0] rd_data, rd_data1;

    int n_chk = 0, n_fail = 0, cycles = 0;
    logic [31:0] model [128];

    always #2.5 clk = ~clk;

    vreg_access_unit #(.PARALLEL(0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_spec(req_spec), .req_size(req_size), .req_wdata(req_wdata),
        .req_mask(req_mask), .ready(ready), .done(done), .rd_data(rd_data));

    vreg_access_unit #(.PARALLEL(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid1), .req_write(req_write),
        .req_spec(req_spec), .req_size(req_size), .req_wdata(req_wdata),
        .req_mask(req_mask), .ready(ready1), .done(done1), .rd_data(rd_data1));

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arithmetic model of element placement.
    function automatic int elem_idx(input int sp, input int sz, input int i);
        int m, c, t, r;
        m = (sp / 4) % 8;
        c = sp % 4;
        t = (sz == 0) ? 0 : (sp / 32) % 2;
        if (sz == 0)      r = (sp / 32) % 4;
        else if (sz == 2) r = (sp / 64) % 2;
        else              r = ((sp / 64) % 2) * 2;
        if (t != 0) return m * 4 + (r + i) % 4 + c * 32;
        return m * 4 + c + ((r + i) % 4) * 32;
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    // One request to both instances; checks latency, pulse width and read data.
    task automatic do_req(input bit wr, input int sp, input int sz,
                          input logic [127:0] wd, input logic [3:0] mk);
        int c0 = 0, c1 = 0, n = 0;
        logic [127:0] exp = '0;
        logic [127:0] got0 = '0, got1 = '0;
        req_write = wr; req_spec = 7'(sp); req_size = 2'(sz);
        req_wdata = wd; req_mask = mk;
        req_valid = 1'b1; req_valid1 = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_valid1 = 1'b0;
        n = 1;
        while ((c0 == 0 || c1 == 0) && n < 20) begin
            if (done && c0 == 0)  begin c0 = n; got0 = rd_data;  end
            if (done1 && c1 == 0) begin c1 = n; got1 = rd_data1; end
            if (c0 == 0 || c1 == 0) begin @(negedge clk); n++; end
        end
        // R7 serial latency len+1
        check(c0 == sz + 2, "R7 serial done latency", 128'(c0), 128'(sz + 2));
        // R10 parallel latency 2
        check(c1 == 2, "R10 parallel done latency", 128'(c1), 128'd2);
        for (int i = 0; i <= sz; i++) begin
            int ix = elem_idx(sp, sz, i);
            if (wr && !mk[i]) model[ix] = wd[32*i +: 32];
            exp[32*i +: 32] = model[ix];
        end
        if (!wr) begin
            // R1 R2 R3 R4 R6 lane placement and zero lanes
            check(got0 === exp, "R6 serial read data", got0, exp);
            check(got1 === exp, "R10 parallel read data", got1, exp);
        end
        while (!ready || !ready1) @(negedge clk);
        check(!done && !done1, "R7 done single cycle", {done, done1}, 128'd0);
    endtask

    initial begin
        for (int e = 0; e < 128; e++) model[e] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(ready && ready1 && !done && !done1, "R9 ready/done after reset",
              {ready, done}, 128'b10);
        check(rd_data === '0, "R9 rd_data after reset", rd_data, '0);
        do_req(1'b0, 127, 3, '0, 4'h0);
        do_req(1'b0, 32, 2, '0, 4'h0);

        // Sweep every specifier at every size: masked write then read back.
        for (int sz = 0; sz < 4; sz++) begin
            for (int sp = 0; sp < 128; sp++) begin
                int k = sz * 128 + sp;
                logic [127:0] wd;
                logic [3:0] mk;
                for (int i = 0; i < 4; i++)
                    wd[32*i +: 32] = 32'h5A00_0000 ^ (k << 4) ^ i ^ (cycles << 12);
                mk = (k % 5 == 0) ? 4'h0 : 4'((k * 7) % 16);   // R5 masks
                do_req(1'b1, sp, sz, wd, mk);
                do_req(1'b0, sp, sz, '0, 4'h0);
                do_req(1'b0, (sp * 37 + 11) % 128, 3 - sz, '0, 4'h0);
            end
        end

        // R8: second write held while busy through the done cycle.
        begin
            int n = 0;
            req_write = 1'b1; req_spec = 7'd0; req_size = 2'd3;
            req_wdata = {4{32'h1111_2222}}; req_mask = 4'h0;
            req_valid = 1'b1; req_valid1 = 1'b1;
            @(negedge clk);
            req_valid1 = 1'b0;
            for (int i = 0; i < 4; i++) model[elem_idx(0, 3, i)] = 32'h1111_2222;
            req_spec = 7'd1; req_wdata = {4{32'hDEAD_BEEF}};
            while (!done && n < 20) begin @(negedge clk); n++; end
            req_valid = 1'b0;
            @(negedge clk);
            check(ready, "R8 idle after collision", 128'(ready), 128'd1);
            do_req(1'b0, 1, 3, '0, 4'h0);   // R8 target kept old contents
            do_req(1'b0, 0, 3, '0, 4'h0);
        end
        finish_run();
    end
endmodule